// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the sequence of column addresses for a burst access inside one open row of a synchronous DRAM page with 256 columns. A one-cycle start pulse captures a starting column together with the programmed burst length and ordering. From the next cycle on, the block presents one column address per clock, with a valid flag and a flag that marks the final beat.

The burst length can be 1, 2, 4 or 8 beats, or a full page. A full-page burst runs around the row without end until a stop pulse arrives. Finite bursts use either sequential order or interleaved order, and both stay inside the aligned block of the burst length. A start pulse that arrives during a burst replaces that burst at once. Starts on consecutive cycles therefore give a random column on every clock.

Top module: `burst_col_gen`

## Requirements
- R1: When `start` is sampled high at a rising edge, the outputs after that edge show `col_valid`=1 and `col_out` equal to the sampled `start_col`.
- R2: `mode_len` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full page, and 4, 5 and 6 give 1 beat. A finite burst holds `col_valid` high for exactly that many cycles, raises `col_last` only on the final beat, and then drops `col_valid`.
- R3: In sequential order (`mode_ilv`=0), beat k of a length-L burst keeps the column bits above the low log2(L) bits and sets the low bits to (start low bits + k) mod L.
- R4: In interleaved order (`mode_ilv`=1), beat k of a length-L burst is the start column XOR k, with k below L.
- R5: A full-page burst advances the column by one on every cycle and wraps from 255 to 0. It never raises `col_last`. It ends with `col_valid`=0 in the cycle after `stop` is sampled high.
- R6: A full-page burst always uses sequential order, whatever the value of `mode_ilv`.
- R7: A `start` during a burst restarts the sequence at the new column with the new mode. It has priority over `stop` and over the end of a burst.
- R8: `stop` has no effect on a finite-length burst.
- R9: `mode_len` and `mode_ilv` are sampled only together with `start`. Changes to them during a burst have no effect.
- R10: While reset is asserted and after it is released, before any start, `col_valid`=0, `col_last`=0 and `col_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start a burst at `start_col` |
| start_col | input | 8 | Starting column |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 selects interleaved order |
| stop | input | 1 | Ends a full-page burst |
| col_out | output | 8 | Current column address |
| col_valid | output | 1 | `col_out` is a burst beat |
| col_last | output | 1 | Final beat of a finite burst |

## Verification
The assertions assume that `start`, `stop` and the mode inputs are stable around each rising edge and that reset is applied before the first check. They make no assumption about when a start or a stop may arrive. The bench drives every input just after a falling edge. It mixes stops in finite bursts, starts on consecutive cycles, starts together with stops, and mode changes in the middle of a burst. All of these lie within what the assertions accept.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       mode_len,
  input  logic             mode_ilv,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic             active_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q, mask_d;

  always_comb begin
    case (mode_len)
      3'd1:    mask_d = COL_W'(1);
      3'd2:    mask_d = COL_W'(3);
      3'd3:    mask_d = COL_W'(7);
      3'd7:    mask_d = ALL_ONES;
      default: mask_d = '0;
    endcase
  end

  wire [COL_W-1:0] seq_col = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
  wire [COL_W-1:0] ilv_col = base_q ^ (beat_q & mask_q);

  assign col_out   = ilv_q ? ilv_col : seq_col;
  assign col_valid = active_q;
  assign col_last  = active_q && !full_q && (beat_q == mask_q);

  wire burst_end = full_q ? stop : col_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      full_q   <= (mode_len == 3'd7);
      ilv_q    <= mode_ilv && (mode_len != 3'd7);
      base_q   <= start_col;
      beat_q   <= '0;
      mask_q   <= mask_d;
    end else if (active_q) begin
      if (burst_end) active_q <= 1'b0;
      else           beat_q   <= beat_q + 1'b1;
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col_out == $past(start_col)); // R1
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_last && !start |=> !col_valid); // R2
  AST_FINITE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !full_q && !col_last && !start |=> col_valid); // R8
  AST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && $past(col_valid) && !$past(start) && !full_q
      |-> (col_out & ~mask_q) == ($past(col_out) & ~mask_q)); // R3
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && full_q && $past(col_valid) && !$past(start)
      |-> col_out == $past(col_out) + 1'b1); // R5
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !col_last); // R5
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] mode_len = '0;
  logic       mode_ilv = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col_out;
  logic       col_valid, col_last;

  int checks = 0, fails = 0;
  string cur_req = "R10";
  bit monitor_on = 1'b0;

  always #2 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .mode_len(mode_len), .mode_ilv(mode_ilv), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last)
  );

  // behavioural reference: len 0 means full page
  bit m_active = 0;
  int m_base = 0, m_idx = 0, m_len = 1;
  bit m_ilv = 0;

  function automatic int decode_len(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    if (m_len == 0) return (m_base + m_idx) % 256;
    if (m_ilv) return m_base ^ m_idx;
    return (m_base / m_len) * m_len + ((m_base % m_len) + m_idx) % m_len;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_idx = 0;
    end else if (start) begin
      m_active = 1; m_base = start_col; m_idx = 0;
      m_len = decode_len(mode_len);
      m_ilv = mode_ilv && (m_len != 0);
    end else if (m_active) begin
      if (m_len == 0) begin
        if (stop) m_active = 0; else m_idx = (m_idx + 1) % 256;
      end else begin
        if (m_idx == m_len - 1) m_active = 0; else m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (monitor_on) begin
      bit e_last;
      e_last = m_active && m_len != 0 && m_idx == m_len - 1;
      checks++;
      if (col_valid !== m_active || col_last !== e_last ||
          (m_active && col_out !== 8'(exp_col()))) begin
        fails++;
        $display("FAIL %s: valid=%0b last=%0b col=%h expected valid=%0b last=%0b col=%h",
                 cur_req, col_valid, col_last, col_out, m_active, e_last, 8'(exp_col()));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic [7:0] col, input logic [2:0] len, input logic ilv);
    start = 1'b1; start_col = col; mode_len = len; mode_ilv = ilv;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(1);
    cur_req = "R10";
    checks++;
    if (col_valid !== 1'b0 || col_last !== 1'b0 || col_out !== 8'h00) begin
      fails++;
      $display("FAIL R10: in reset valid=%0b last=%0b col=%h expected 0 0 00", col_valid, col_last, col_out);
    end
    idle(2);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    idle(3);
    checks++;
    if (col_valid !== 1'b0 || col_last !== 1'b0 || col_out !== 8'h00) begin
      fails++;
      $display("FAIL R10: after reset valid=%0b last=%0b col=%h expected 0 0 00", col_valid, col_last, col_out);
    end

    cur_req = "R2";
    for (int c = 0; c < 7; c++) begin kick(8'h35, 3'(c), 1'b0); idle(10); end
    cur_req = "R3";
    kick(8'h3D, 3'd3, 1'b0); idle(10);
    kick(8'h83, 3'd2, 1'b0); idle(6);
    kick(8'hFF, 3'd1, 1'b0); idle(4);
    cur_req = "R4";
    kick(8'h3D, 3'd3, 1'b1); idle(10);
    kick(8'h82, 3'd2, 1'b1); idle(6);
    kick(8'h01, 3'd1, 1'b1); idle(4);
    cur_req = "R5";
    kick(8'hFC, 3'd7, 1'b0); idle(300);
    stop = 1'b1; idle(1); stop = 1'b0; idle(4);
    cur_req = "R6";
    kick(8'h10, 3'd7, 1'b1); idle(20);
    stop = 1'b1; idle(1); stop = 1'b0; idle(4);
    cur_req = "R7";
    kick(8'h20, 3'd3, 1'b0); idle(3);
    kick(8'h91, 3'd2, 1'b1); idle(8);
    for (int i = 0; i < 12; i++) kick(8'((i * 37 + 5) % 256), 3'd0, 1'b0);
    kick(8'h44, 3'd7, 1'b0); idle(5);
    stop = 1'b1; kick(8'h6B, 3'd2, 1'b0); stop = 1'b0; idle(6);
    kick(8'h50, 3'd1, 1'b0); idle(1);
    kick(8'h57, 3'd3, 1'b1); idle(10);
    cur_req = "R8";
    kick(8'hA5, 3'd3, 1'b0);
    stop = 1'b1; idle(3); stop = 1'b0; idle(8);
    cur_req = "R9";
    kick(8'hC6, 3'd3, 1'b1);
    mode_len = 3'd0; mode_ilv = 1'b0; idle(10);
    kick(8'h0E, 3'd2, 1'b0);
    mode_len = 3'd7; mode_ilv = 1'b1; idle(8);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule